// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It uses four tables that are read at the same time. The fallback table is an untagged array of 2-bit counters, addressed by the branch address alone. The other three tables are tagged, and each one hashes the branch address with a longer and longer window of recent branch outcomes. Among the tagged tables whose partial tag matches, the one with the longest history window supplies the guess. When no tagged table matches, the fallback table supplies it.

The lookup port is combinational. It takes a branch address and returns four things: the predicted direction, which table supplied it, the hit vector and an alternate guess. The alternate guess is what the next-shorter matching table, or the fallback table, would have said. The lookup port also returns the history value it used. The front end keeps these values with the branch and hands them back on the update port when the branch resolves, together with the real outcome.

On update, the block trains the table that supplied the guess and shifts the outcome into the history. If the guess was wrong, it places a new entry in a table with a longer history window. Each tagged entry has a useful bit, and these bits decide which entries may be overwritten. All useful bits are also cleared on a fixed period, so no entry stays protected for ever.

Top module: `tage_dir_pred`

## Requirements
- R1: After reset, the history is zero, no tagged table hits, the provider code is 0, and every fallback counter predicts not-taken (weak not-taken, value 1).
- R2: The fallback table holds 2-bit saturating counters. Its 6-bit index is the XOR of all 6-bit chunks of the address, starting at bit 0. It predicts taken when its counter is 2 or more. It is trained only when the provider code of the update is 0.
- R3: Provider code 0 means the fallback table and code k (1 to 3) means tagged table k. Hit bit k-1 reports a match in table k. The provider is the highest-numbered hitting table. The alternate guess comes from the next lower hitting table, or from the fallback table when there is none.
- R4: Each accepted update shifts the history left by one and puts the outcome (1 = taken) into bit 0. Tables 1, 2 and 3 use the low 2, 8 and 32 history bits.
- R5: For tagged table k, the index is the fallback index XORed with the 6-bit chunk fold of its masked history. The tag is the 8-bit chunk fold of the address shifted right by 6, XORed with the 8-bit chunk fold of that same masked history. An entry hits only if it is valid and its tag matches.
- R6: Tagged counters are 3-bit and saturating, and they predict taken when the value is 4 or more. On an update from a tagged provider, that provider's counter moves one step toward the outcome.
- R7: On a misprediction, the block picks the lowest-numbered table above the provider whose entry at the update index has useful bit 0. That entry is written valid, with the new tag, counter 4 if the branch was taken or 3 if not, and useful bit 0.
- R8: If every table above the provider has its useful bit at 1, nothing is allocated and those useful bits are cleared.
- R9: When a tagged provider's guess differed from the alternate guess, its useful bit is set if the guess was right and cleared if it was wrong. The useful bit does not change when the two guesses agree.
- R10: Every 256th accepted update clears all useful bits, and this clear overrides any other useful-bit write in that cycle.
- R11: While the update-valid input is low, no table and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | PC_W | Lookup branch address |
| lk_taken_o | output | 1 | Predicted direction (1 = taken) |
| lk_provider_o | output | 2 | Providing table (0 = fallback) |
| lk_alt_o | output | 1 | Alternate guess |
| lk_hits_o | output | 3 | Tag-hit vector of tables 1..3 |
| lk_ghr_o | output | 32 | History used by this lookup |
| upd_valid_i | input | 1 | Update strobe |
| upd_pc_i | input | PC_W | Resolved branch address |
| upd_ghr_i | input | 32 | History snapshot from lookup |
| upd_provider_i | input | 2 | Provider snapshot |
| upd_pred_i | input | 1 | Prediction snapshot |
| upd_alt_i | input | 1 | Alternate-guess snapshot |
| upd_taken_i | input | 1 | Resolved outcome |

## Verification
Several outcome patterns are run against a scoreboard model:
- An always-taken branch shows that the fallback counters train and saturate.
- A strictly alternating branch only becomes predictable once the short-history table has learned it, so it checks allocation and the move of the provider role.
- A taken-taken-taken-not-taken loop branch placed among constant branches needs the eight-bit table, and it exercises the useful-bit rules.
- A pseudo-random mix over many addresses fills the tables until allocation is blocked.
- A branch whose outcome copies an earlier branch, run past 256 and 512 updates, shows whether the periodic useful-bit clear happens at the right update.
- Pairs of addresses that differ only in their high bits test the index and tag hashing.
- Bursts of junk on the update inputs with the strobe low must leave every later prediction unchanged.

// File: rtl/tage_pkg.sv
package tage_pkg;
  localparam int GHR_W    = 32;
  localparam int IDX_W    = 6;
  localparam int TAG_W    = 8;
  localparam int CTR_W    = 3;
  localparam int BASE_W   = 2;
  localparam int N_TAGGED = 3;
  localparam int PROV_W   = 2;
  localparam int FOLD_W   = 64;
  localparam int DEPTH    = 1 << IDX_W;

  function automatic logic [FOLD_W-1:0] keep_low(logic [FOLD_W-1:0] v, int len);
    logic [FOLD_W-1:0] m;
    for (int k = 0; k < FOLD_W; k++) m[k] = (k < len);
    return v & m;
  endfunction

  function automatic logic [IDX_W-1:0] fold_idx(logic [FOLD_W-1:0] v);
    logic [IDX_W-1:0]  acc;
    logic [FOLD_W-1:0] s;
    acc = '0;
    for (int i = 0; i < FOLD_W; i += IDX_W) begin
      s = v >> i;
      acc ^= s[IDX_W-1:0];
    end
    return acc;
  endfunction

  function automatic logic [TAG_W-1:0] fold_tag(logic [FOLD_W-1:0] v);
    logic [TAG_W-1:0]  acc;
    logic [FOLD_W-1:0] s;
    acc = '0;
    for (int i = 0; i < FOLD_W; i += TAG_W) begin
      s = v >> i;
      acc ^= s[TAG_W-1:0];
    end
    return acc;
  endfunction
endpackage

// File: rtl/tage_base_table.sv
module tage_base_table
  import tage_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_taken_o,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_en_i,
  input  logic            up_taken_i
);
  localparam logic [BASE_W-1:0] WEAK_NT = BASE_W'((1 << (BASE_W-1)) - 1);
  localparam logic [BASE_W-1:0] CTR_MAX = '1;

  logic [BASE_W-1:0] ctr_q [DEPTH];
  logic [IDX_W-1:0]  lk_idx, up_idx;

  assign lk_idx     = fold_idx(FOLD_W'(lk_pc_i));
  assign up_idx     = fold_idx(FOLD_W'(up_pc_i));
  assign lk_taken_o = ctr_q[lk_idx][BASE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= WEAK_NT;
    end else if (up_en_i) begin
      if (up_taken_i && ctr_q[up_idx] != CTR_MAX)
        ctr_q[up_idx] <= ctr_q[up_idx] + 1'b1;
      else if (!up_taken_i && ctr_q[up_idx] != '0)
        ctr_q[up_idx] <= ctr_q[up_idx] - 1'b1;
    end
  end
endmodule

// File: rtl/tage_tagged_bank.sv
module tage_tagged_bank
  import tage_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int HIST_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lk_pc_i,
  input  logic [GHR_W-1:0] lk_ghr_i,
  output logic             lk_hit_o,
  output logic             lk_taken_o,
  input  logic [PC_W-1:0]  up_pc_i,
  input  logic [GHR_W-1:0] up_ghr_i,
  output logic             up_u_o,
  input  logic             up_taken_i,
  input  logic             ctr_en_i,
  input  logic             u_wr_en_i,
  input  logic             u_wr_val_i,
  input  logic             alloc_en_i,
  input  logic             u_clr_one_i,
  input  logic             u_clr_all_i
);
  localparam logic [CTR_W-1:0] WEAK_T  = CTR_W'(1 << (CTR_W-1));
  localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W-1)) - 1);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic             valid_q [DEPTH];
  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [CTR_W-1:0] ctr_q   [DEPTH];
  logic             u_q     [DEPTH];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [FOLD_W-1:0] lk_h, up_h;

  assign lk_h   = keep_low(FOLD_W'(lk_ghr_i), HIST_LEN);
  assign up_h   = keep_low(FOLD_W'(up_ghr_i), HIST_LEN);
  assign lk_idx = fold_idx(FOLD_W'(lk_pc_i)) ^ fold_idx(lk_h);
  assign up_idx = fold_idx(FOLD_W'(up_pc_i)) ^ fold_idx(up_h);
  assign lk_tag = fold_tag(FOLD_W'(lk_pc_i) >> IDX_W) ^ fold_tag(lk_h);
  assign up_tag = fold_tag(FOLD_W'(up_pc_i) >> IDX_W) ^ fold_tag(up_h);

  assign lk_hit_o   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_taken_o = ctr_q[lk_idx][CTR_W-1];
  assign up_u_o     = u_q[up_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) begin
        valid_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        ctr_q[e]   <= WEAK_NT;
      end
    end else if (alloc_en_i) begin
      valid_q[up_idx] <= 1'b1;
      tag_q[up_idx]   <= up_tag;
      ctr_q[up_idx]   <= up_taken_i ? WEAK_T : WEAK_NT;
    end else if (ctr_en_i) begin
      if (up_taken_i && ctr_q[up_idx] != CTR_MAX)
        ctr_q[up_idx] <= ctr_q[up_idx] + 1'b1;
      else if (!up_taken_i && ctr_q[up_idx] != '0)
        ctr_q[up_idx] <= ctr_q[up_idx] - 1'b1;
    end
  end

  // periodic clear wins over every per-entry write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) u_q[e] <= 1'b0;
    end else if (u_clr_all_i) begin
      for (int e = 0; e < DEPTH; e++) u_q[e] <= 1'b0;
    end else if (alloc_en_i || u_clr_one_i) begin
      u_q[up_idx] <= 1'b0;
    end else if (u_wr_en_i) begin
      u_q[up_idx] <= u_wr_val_i;
    end
  end
endmodule

// File: rtl/tage_update_ctrl.sv
module tage_update_ctrl
  import tage_pkg::*;
(
  input  logic                valid_i,
  input  logic [PROV_W-1:0]   provider_i,
  input  logic                pred_i,
  input  logic                alt_i,
  input  logic                taken_i,
  input  logic [N_TAGGED-1:0] up_u_i,
  output logic                base_en_o,
  output logic [N_TAGGED-1:0] ctr_en_o,
  output logic [N_TAGGED-1:0] u_wr_en_o,
  output logic                u_wr_val_o,
  output logic [N_TAGGED-1:0] alloc_en_o,
  output logic [N_TAGGED-1:0] u_clr_one_o
);
  logic mispred;
  logic found;

  assign mispred    = pred_i ^ taken_i;
  assign base_en_o  = valid_i && (provider_i == '0);
  assign u_wr_val_o = !mispred;

  always_comb begin
    found       = 1'b0;
    ctr_en_o    = '0;
    u_wr_en_o   = '0;
    alloc_en_o  = '0;
    u_clr_one_o = '0;
    for (int t = 0; t < N_TAGGED; t++) begin
      ctr_en_o[t]  = valid_i && (provider_i == PROV_W'(t + 1));
      u_wr_en_o[t] = valid_i && (provider_i == PROV_W'(t + 1)) && (pred_i != alt_i);
      if (valid_i && mispred && (PROV_W'(t + 1) > provider_i) && !found && !up_u_i[t]) begin
        alloc_en_o[t] = 1'b1;
        found         = 1'b1;
      end
    end
    for (int t = 0; t < N_TAGGED; t++)
      u_clr_one_o[t] = valid_i && mispred && (PROV_W'(t + 1) > provider_i) && !found;
  end
endmodule

// File: rtl/tage_dir_pred.sv
module tage_dir_pred
  import tage_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST1  = 2,
  parameter int HIST2  = 8,
  parameter int HIST3  = 32,
  parameter int UCLR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lk_pc_i,
  output logic              lk_taken_o,
  output logic [PROV_W-1:0] lk_provider_o,
  output logic              lk_alt_o,
  output logic [N_TAGGED-1:0] lk_hits_o,
  output logic [GHR_W-1:0]  lk_ghr_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [GHR_W-1:0]  upd_ghr_i,
  input  logic [PROV_W-1:0] upd_provider_i,
  input  logic              upd_pred_i,
  input  logic              upd_alt_i,
  input  logic              upd_taken_i
);
  localparam int HIST_LENS [N_TAGGED] = '{HIST1, HIST2, HIST3};

  logic [GHR_W-1:0]    ghr_q;
  logic [UCLR_W-1:0]   ucnt_q;
  logic                base_tk, base_en, u_clr_all, u_wr_val;
  logic [N_TAGGED-1:0] hit, tk, up_u, ctr_en, u_wr_en, alloc_en, u_clr_one;

  tage_base_table #(.PC_W(PC_W)) u_base (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_pc_i    (lk_pc_i),
    .lk_taken_o (base_tk),
    .up_pc_i    (upd_pc_i),
    .up_en_i    (base_en),
    .up_taken_i (upd_taken_i)
  );

  for (genvar g = 0; g < N_TAGGED; g++) begin : g_bank
    tage_tagged_bank #(.PC_W(PC_W), .HIST_LEN(HIST_LENS[g])) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lk_pc_i     (lk_pc_i),
      .lk_ghr_i    (ghr_q),
      .lk_hit_o    (hit[g]),
      .lk_taken_o  (tk[g]),
      .up_pc_i     (upd_pc_i),
      .up_ghr_i    (upd_ghr_i),
      .up_u_o      (up_u[g]),
      .up_taken_i  (upd_taken_i),
      .ctr_en_i    (ctr_en[g]),
      .u_wr_en_i   (u_wr_en[g]),
      .u_wr_val_i  (u_wr_val),
      .alloc_en_i  (alloc_en[g]),
      .u_clr_one_i (u_clr_one[g]),
      .u_clr_all_i (u_clr_all)
    );
  end

  tage_update_ctrl u_ctrl (
    .valid_i     (upd_valid_i),
    .provider_i  (upd_provider_i),
    .pred_i      (upd_pred_i),
    .alt_i       (upd_alt_i),
    .taken_i     (upd_taken_i),
    .up_u_i      (up_u),
    .base_en_o   (base_en),
    .ctr_en_o    (ctr_en),
    .u_wr_en_o   (u_wr_en),
    .u_wr_val_o  (u_wr_val),
    .alloc_en_o  (alloc_en),
    .u_clr_one_o (u_clr_one)
  );

  // ascending scan: each later hit pushes the earlier guess to alternate
  always_comb begin
    lk_taken_o    = base_tk;
    lk_alt_o      = base_tk;
    lk_provider_o = '0;
    for (int t = 0; t < N_TAGGED; t++) begin
      if (hit[t]) begin
        lk_alt_o      = lk_taken_o;
        lk_taken_o    = tk[t];
        lk_provider_o = PROV_W'(t + 1);
      end
    end
  end

  assign lk_hits_o = hit;
  assign lk_ghr_o  = ghr_q;
  assign u_clr_all = upd_valid_i && (ucnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ghr_q  <= '0;
      ucnt_q <= '0;
    end else if (upd_valid_i) begin
      ghr_q  <= {ghr_q[GHR_W-2:0], upd_taken_i};
      ucnt_q <= ucnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tage_dir_pred_chk.sv
module tage_dir_pred_chk
  import tage_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                lk_taken_o,
  input logic [PROV_W-1:0]   lk_provider_o,
  input logic                lk_alt_o,
  input logic [N_TAGGED-1:0] lk_hits_o,
  input logic [GHR_W-1:0]    lk_ghr_o,
  input logic                upd_valid_i,
  input logic                upd_taken_i
);
  p_prov_is_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_provider_o != '0) |-> lk_hits_o[lk_provider_o - 1'b1]);

  p_prov_longest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hits_o >> lk_provider_o) == '0);

  p_alt_nohit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hits_o == '0) |-> (lk_alt_o == lk_taken_o));

  p_ghr_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (lk_ghr_o == {$past(lk_ghr_o[GHR_W-2:0]), $past(upd_taken_i)}));

  p_ghr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(lk_ghr_o));
endmodule

bind tage_dir_pred tage_dir_pred_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_taken_o    (lk_taken_o),
  .lk_provider_o (lk_provider_o),
  .lk_alt_o      (lk_alt_o),
  .lk_hits_o     (lk_hits_o),
  .lk_ghr_o      (lk_ghr_o),
  .upd_valid_i   (upd_valid_i),
  .upd_taken_i   (upd_taken_i)
);

// File: tb/tage_dir_pred_bench.sv
module tage_dir_pred_bench;
  typedef struct packed {
    logic        taken;
    logic [1:0]  prov;
    logic        alt;
    logic [2:0]  hits;
    logic [31:0] ghr;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        lk_taken_o, lk_alt_o;
  logic [1:0]  lk_provider_o;
  logic [2:0]  lk_hits_o;
  logic [31:0] lk_ghr_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic [31:0] upd_ghr_i = '0;
  logic [1:0]  upd_provider_i = '0;
  logic        upd_pred_i = 1'b0, upd_alt_i = 1'b0, upd_taken_i = 1'b0;

  always #10 clk_i = ~clk_i;

  tage_dir_pred u_tage_dir_pred (
    .clk_i, .rst_ni, .lk_pc_i, .lk_taken_o, .lk_provider_o, .lk_alt_o,
    .lk_hits_o, .lk_ghr_o, .upd_valid_i, .upd_pc_i, .upd_ghr_i,
    .upd_provider_i, .upd_pred_i, .upd_alt_i, .upd_taken_i
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string req_q[$];

  // reference state, built from the requirement text
  bit          m_val [3][64];
  logic [7:0]  m_tag [3][64];
  int          m_ctr [3][64];
  bit          m_u   [3][64];
  int          m_base[64];
  logic [31:0] m_ghr;
  int          m_cnt;
  int          hl[3] = '{2, 8, 32};
  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic logic [5:0] m_idx(logic [31:0] pc, logic [31:0] h, int len);
    logic [5:0] r = '0;
    for (int k = 0; k < 32; k++) r[k % 6] ^= pc[k];
    for (int k = 0; k < len; k++) r[k % 6] ^= h[k];
    return r;
  endfunction

  function automatic logic [7:0] m_tagf(logic [31:0] pc, logic [31:0] h, int len);
    logic [7:0] r = '0;
    for (int k = 6; k < 32; k++) r[(k - 6) % 8] ^= pc[k];
    for (int k = 0; k < len; k++) r[k % 8] ^= h[k];
    return r;
  endfunction

  function automatic exp_t m_lookup(logic [31:0] pc);
    exp_t e;
    e.taken = (m_base[m_idx(pc, m_ghr, 0)] >= 2);
    e.alt = e.taken; e.prov = 0; e.hits = '0; e.ghr = m_ghr;
    for (int t = 0; t < 3; t++) begin
      if (m_val[t][m_idx(pc, m_ghr, hl[t])] &&
          m_tag[t][m_idx(pc, m_ghr, hl[t])] == m_tagf(pc, m_ghr, hl[t])) begin
        e.hits[t] = 1'b1;
        e.alt = e.taken;
        e.taken = (m_ctr[t][m_idx(pc, m_ghr, hl[t])] >= 4);
        e.prov = 2'(t + 1);
      end
    end
    return e;
  endfunction

  task automatic m_update(logic [31:0] pc, exp_t e, logic tk);
    int  ix[3];
    int  bi, p;
    bit  mis, found;
    bi = m_idx(pc, m_ghr, 0);
    for (int t = 0; t < 3; t++) ix[t] = m_idx(pc, m_ghr, hl[t]);
    mis = (e.taken != tk);
    p = e.prov;
    if (p == 0) begin                                   // R2
      if (tk && m_base[bi] < 3) m_base[bi]++;
      else if (!tk && m_base[bi] > 0) m_base[bi]--;
    end else begin                                      // R6
      if (tk && m_ctr[p-1][ix[p-1]] < 7) m_ctr[p-1][ix[p-1]]++;
      else if (!tk && m_ctr[p-1][ix[p-1]] > 0) m_ctr[p-1][ix[p-1]]--;
      if (e.taken != e.alt) m_u[p-1][ix[p-1]] = !mis;   // R9
    end
    if (mis && p < 3) begin
      found = 0;
      for (int t = p; t < 3; t++) begin                 // R7
        if (!found && !m_u[t][ix[t]]) begin
          m_val[t][ix[t]] = 1; m_tag[t][ix[t]] = m_tagf(pc, m_ghr, hl[t]);
          m_ctr[t][ix[t]] = tk ? 4 : 3; m_u[t][ix[t]] = 0; found = 1;
        end
      end
      if (!found) for (int t = p; t < 3; t++) m_u[t][ix[t]] = 0;  // R8
    end
    m_cnt = (m_cnt + 1) % 256;
    if (m_cnt == 0)                                     // R10
      for (int t = 0; t < 3; t++) for (int i = 0; i < 64; i++) m_u[t][i] = 0;
    m_ghr = {m_ghr[30:0], tk};                          // R4
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected items as lookup results become stable
  initial begin
    forever begin
      @(negedge clk_i);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(r, "taken", 32'(lk_taken_o), 32'(e.taken));
        chk(r, "alt", 32'(lk_alt_o), 32'(e.alt));
        chk("R3", "provider", 32'(lk_provider_o), 32'(e.prov));
        chk("R3", "hits", 32'(lk_hits_o), 32'(e.hits));
        chk("R4", "ghr", lk_ghr_o, e.ghr);
      end
    end
  end

  task automatic probe(logic [31:0] pc, string req);
    @(posedge clk_i); #1;
    upd_valid_i = 1'b0;
    lk_pc_i = pc;
    exp_q.push_back(m_lookup(pc));
    req_q.push_back(req);
    @(negedge clk_i); #1;
  endtask

  task automatic branch(logic [31:0] pc, logic tk, string req);
    exp_t e;
    @(posedge clk_i); #1;
    upd_valid_i = 1'b0;
    lk_pc_i = pc;
    e = m_lookup(pc);
    exp_q.push_back(e);
    req_q.push_back(req);
    @(negedge clk_i); #1;
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_ghr_i = e.ghr;
    upd_provider_i = e.prov; upd_pred_i = e.taken; upd_alt_i = e.alt;
    upd_taken_i = tk;
    m_update(pc, e, tk);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic idle_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      step_lfsr();
      upd_valid_i = 1'b0; upd_pc_i = lfsr; upd_ghr_i = ~lfsr;
      upd_provider_i = lfsr[1:0]; upd_pred_i = lfsr[2];
      upd_alt_i = lfsr[3]; upd_taken_i = lfsr[4];
    end
  endtask

  initial begin
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 64; i++) begin
        m_val[t][i] = 0; m_tag[t][i] = '0; m_ctr[t][i] = 3; m_u[t][i] = 0;
      end
    for (int i = 0; i < 64; i++) m_base[i] = 1;
    m_ghr = '0; m_cnt = 0;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: reset state seen on several addresses
    probe(32'h0000_0000, "R1");
    probe(32'h0000_1234, "R1");
    probe(32'hFFFF_FFC0, "R1");

    // R2: always-taken branch trains the fallback counter
    for (int i = 0; i < 12; i++) branch(32'h0000_0040, 1'b1, "R2");

    // R6: alternating branch handed to a tagged table
    for (int i = 0; i < 40; i++) branch(32'h0000_0104, 1'(i % 2), "R6");

    // R9: loop branch T T T N among constant branches
    for (int i = 0; i < 30; i++) begin
      branch(32'h0000_2208, 1'((i % 4) != 3), "R9");
      branch(32'h0000_3310, 1'b0, "R9");
    end

    // R7 / R8: random outcomes over many addresses fill the tables
    for (int i = 0; i < 120; i++) begin
      step_lfsr();
      branch({20'h0, lfsr[11:2], 2'b00}, lfsr[17], (i % 2) ? "R7" : "R8");
    end

    // R5: addresses that differ only in upper bits
    for (int i = 0; i < 20; i++) begin
      branch(32'h0000_0500, 1'b1, "R5");
      branch(32'h0010_0500, 1'b0, "R5");
      branch(32'h8000_0500, 1'(i % 2), "R5");
    end

    // R11: junk on update inputs with strobe low changes nothing
    idle_junk(6);
    probe(32'h0000_0104, "R11");
    probe(32'h0000_2208, "R11");
    idle_junk(4);
    probe(32'h0000_0040, "R11");

    // R10: correlated pair run across several clear periods
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      branch(32'h0000_0600 + {28'h0, lfsr[3:2], 2'b00}, lfsr[9], "R10");
      branch(32'h0000_0700, m_ghr[0], "R10");
    end

    // R4: history after a burst of known outcomes
    for (int i = 0; i < 8; i++) branch(32'h0000_0900, 1'(i == 3), "R4");
    probe(32'h0000_0900, "R4");
    probe(32'h0000_0900, "R4");

    repeat (3) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule